// File: doc/BRIEF.md
# Grouped Carry-Skip Adder

This block adds two 32-bit operands and a carry-in. It returns a 32-bit sum and a carry-out. It is purely combinational. The carry path is split into four groups of unequal size, with bit ranges [3:0], [9:4], [27:10] and [31:28]. The aim is a shorter worst-case path than a plain ripple chain gives.

Inside each group, the bits get a lookahead-style carry chain, and that chain is evaluated twice: once with an incoming carry of zero and once with one. The carry that actually reaches the group then picks the finished sum slice.

A group-wide propagate term works as the skip. When every bit in the group has exactly one operand bit set, the incoming carry is passed straight to the next group and the group's internal chain is bypassed. The block is meant to sit in a larger datapath as a single adder with no clock of its own.

Top module: `grouped_skip_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the arithmetic value `a + b + cin` taken as a 33-bit result.
- R2: With `a = 32'hFFFF_FFFF`, `b = 0` and `cin = 1`, the result is `sum = 0` with `cout = 1`. The carry-in travels across all four groups.
- R3: The carries between groups enter at bits 4, 10 and 28. Each one equals the carry-out of adding all lower bits together with `cin`. For example, `a = 32'h0000_000F`, `b = 1`, `cin = 0` yields `sum = 32'h0000_0010`.
- R4: Skip behaviour. When `a ^ b` is all ones over a group's bit range, the carry leaving that group equals the carry entering it. For example, `a = 32'h0000_03FF`, `b = 1` yields `32'h0000_0400`.
- R5: When some bit of a group does not propagate, the carry leaving the group depends only on that group's operand slice. It equals the carry-out of the slice added with an incoming carry of zero.
- R6: Each group's sum bits equal the low bits of that group's operand slices added to the carry entering the group.
- R7: The outputs are a pure function of the present inputs. There is no clock, no state and no reset. With `a = b = 0` and `cin = 0`, the result is zero with no carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the total |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The assertions assume that the operands and carry-in are settled two-state values whenever the combinational logic is evaluated, so every comparison against a plain arithmetic reference is meaningful.

The bench meets that assumption by driving only known values and waiting one time unit before it reads the outputs. It also keeps every operand change away from the moments it samples.

The directed cases then aim at the carry boundaries at bits 4, 10, 28 and 32. They cover full-group propagation that forces the skip path, and generate-only groups where the skip path must stay unused. Random vectors fill in the rest of the operand space.

// File: rtl/gsa_pkg.sv
package gsa_pkg;
  localparam int NGRP = 4;
  localparam int GRP_W [NGRP] = '{4, 6, 18, 4};

  function automatic int grp_lo(input int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += GRP_W[i];
    return s;
  endfunction

  function automatic int total_width();
    return grp_lo(NGRP);
  endfunction

  localparam int WIDTH = total_width();
endpackage

// File: rtl/gsa_carry_chain.sv
module gsa_carry_chain #(
  parameter int W   = 4,
  parameter bit CIN = 1'b0
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  output logic [W:0]   carry
);
  // lookahead form: each carry is the OR over all lower generate terms
  // whose path up to this bit propagates
  always_comb begin
    for (int i = 0; i <= W; i++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      carry[i] = acc | (run & CIN);
    end
  end
endmodule

// File: rtl/gsa_group.sv
module gsa_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W-1:0] prop, gen;
  logic [W:0]   c_lo, c_hi;
  logic         grp_prop;

  assign prop = a ^ b;
  assign gen  = a & b;

  gsa_carry_chain #(.W(W), .CIN(1'b0)) u_chain0 (
    .gen(gen), .prop(prop), .carry(c_lo)
  );
  gsa_carry_chain #(.W(W), .CIN(1'b1)) u_chain1 (
    .gen(gen), .prop(prop), .carry(c_hi)
  );

  assign grp_prop = &prop;

  // conditional sum: both candidates ready, late carry selects
  assign s = cin ? (prop ^ c_hi[W-1:0]) : (prop ^ c_lo[W-1:0]);

  // skip: a fully propagating group hands the incoming carry onward
  assign cout = grp_prop ? cin : (cin ? c_hi[W] : c_lo[W]);
endmodule

// File: rtl/grouped_skip_adder.sv
module grouped_skip_adder (
  input  logic [gsa_pkg::WIDTH-1:0] a,
  input  logic [gsa_pkg::WIDTH-1:0] b,
  input  logic                      cin,
  output logic [gsa_pkg::WIDTH-1:0] sum,
  output logic                      cout
);
  import gsa_pkg::*;

  logic [NGRP:0] gc;

  assign gc[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int LO = grp_lo(k);
    localparam int GW = GRP_W[k];
    gsa_group #(.W(GW)) u_grp (
      .a   (a[LO +: GW]),
      .b   (b[LO +: GW]),
      .cin (gc[k]),
      .s   (sum[LO +: GW]),
      .cout(gc[k+1])
    );
  end

  assign cout = gc[NGRP];
endmodule

// File: rtl/gsa_checker.sv
module gsa_checker (
  input logic [gsa_pkg::WIDTH-1:0] a,
  input logic [gsa_pkg::WIDTH-1:0] b,
  input logic                      cin,
  input logic [gsa_pkg::WIDTH-1:0] sum,
  input logic                      cout,
  input logic [gsa_pkg::NGRP:0]    gc
);
  import gsa_pkg::*;

  logic [WIDTH:0] ref_full;
  assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_TOTAL_MATCH: assert ({cout, sum} == ref_full); // R1
    if (a == '1 && b == '0 && cin)
      AST_FULL_RIPPLE: assert (sum == '0 && cout); // R2
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_chk
    localparam int LO = grp_lo(k);
    localparam int GW = GRP_W[k];
    logic [GW:0] ref_in, ref_zero;
    logic [LO:0] ref_low;
    assign ref_in   = {1'b0, a[LO +: GW]} + {1'b0, b[LO +: GW]} + {{GW{1'b0}}, gc[k]};
    assign ref_zero = {1'b0, a[LO +: GW]} + {1'b0, b[LO +: GW]};
    if (k > 0) begin : g_low
      assign ref_low = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]} + {{LO{1'b0}}, cin};
    end else begin : g_none
      assign ref_low = cin;
    end
    always_comb begin
      AST_BOUNDARY_CARRY: assert (gc[k] == ref_low[LO]); // R3
      if ((a[LO +: GW] ^ b[LO +: GW]) == '1)
        AST_SKIP_PASS: assert (gc[k+1] == gc[k]); // R4
      else
        AST_LOCAL_CARRY: assert (gc[k+1] == ref_zero[GW]); // R5
      AST_SLICE_SUM: assert (sum[LO +: GW] == ref_in[GW-1:0]); // R6
    end
  end
endmodule

bind grouped_skip_adder gsa_checker u_gsa_checker (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .gc(gc)
);

// File: tb/grouped_skip_adder_test.sv
module grouped_skip_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grouped_skip_adder uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
    @(negedge clk);
    a = ta; b = tb; cin = tc;
    #1;
  endtask

  task automatic expect_val(input string req, input logic [W-1:0] es, input logic ec);
    n_cmp++;
    if (sum !== es || cout !== ec) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%0b got cout=%0b sum=%h expected cout=%0b sum=%h",
               req, a, b, cin, cout, sum, ec, es);
    end
  endtask

  task automatic check_ref(input string req);
    logic [W:0] r;
    r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    expect_val(req, r[W-1:0], r[W]);
  endtask

  task automatic t_idle_r7();
    apply('0, '0, 1'b0); expect_val("R7", 32'h0, 1'b0);
    apply(32'h1234_5678, 32'h1111_1111, 1'b0); expect_val("R7", 32'h2345_6789, 1'b0);
    apply('0, '0, 1'b0); expect_val("R7", 32'h0, 1'b0);
  endtask

  task automatic t_full_ripple_r2();
    apply(32'hFFFF_FFFF, 32'h0, 1'b1); expect_val("R2", 32'h0, 1'b1);
    apply(32'h0, 32'hFFFF_FFFF, 1'b1); expect_val("R2", 32'h0, 1'b1);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1); expect_val("R2", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_boundaries_r3();
    apply(32'h0000_000F, 32'h1, 1'b0); expect_val("R3", 32'h0000_0010, 1'b0);
    apply(32'h0000_0008, 32'h8, 1'b0); expect_val("R3", 32'h0000_0010, 1'b0);
    apply(32'h0000_0200, 32'h200, 1'b0); expect_val("R3", 32'h0000_0400, 1'b0);
    apply(32'h0800_0000, 32'h0800_0000, 1'b0); expect_val("R3", 32'h1000_0000, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 1'b0); expect_val("R3", 32'h0, 1'b1);
  endtask

  task automatic t_skip_r4();
    apply(32'h0000_03FF, 32'h1, 1'b0); expect_val("R4", 32'h0000_0400, 1'b0);
    apply(32'h0FFF_FFF0, 32'h0, 1'b1); expect_val("R4", 32'h0FFF_FFF1, 1'b0);
    apply(32'h0FFF_FFFF, 32'h0, 1'b1); expect_val("R4", 32'h1000_0000, 1'b0);
    apply(32'hF000_0000, 32'h0FFF_FFFF, 1'b1); expect_val("R4", 32'h0, 1'b1);
  endtask

  task automatic t_local_r5();
    apply(32'h0000_0030, 32'h0000_0030, 1'b1); expect_val("R5", 32'h0000_0061, 1'b0);
    apply(32'h0000_0010, 32'h0000_03F0, 1'b0); expect_val("R5", 32'h0000_0400, 1'b0);
    apply(32'h0000_0200, 32'h0000_0200, 1'b1); expect_val("R5", 32'h0000_0401, 1'b0);
  endtask

  task automatic t_slices_r6();
    apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1); expect_val("R6", 32'h0, 1'b1);
    apply(32'h1357_9BDF, 32'h2468_ACE0, 1'b0); check_ref("R6");
  endtask

  task automatic t_random_r1();
    for (int i = 0; i < 2000; i++) begin
      apply($urandom, $urandom, 1'($urandom));
      check_ref("R1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle_r7();
    t_full_ripple_r2();
    t_boundaries_r3();
    t_skip_r4();
    t_local_r5();
    t_slices_r6();
    t_random_r1();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule